// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is one general-purpose I/O port of up to eight pins, programmed over a plain 32-bit register bus. Software owns each pin's output value and direction unless a per-pin mode bit hands the pin to an on-chip peripheral. When a peripheral owns a pin, that peripheral's output and output-enable drive the pad.

The data register uses the access address as a pin mask. Word-address bits [9:2] select which pins a data access touches, so a driver can set, clear or sample any subset of pins in one bus access without a read-modify-write.

Every pin input passes through a two-flop synchronizer and feeds a per-pin interrupt detector. Each detector is set to edge or level sensing and to a single or both edges, and it has a polarity. Latched edges sit in a raw status vector. Enable bits mask that vector into a masked status, and the OR of the masked status is registered onto a single interrupt line. Writing ones to a clear register drops latched edges.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset every register reads 0. All pins are therefore inputs under software control with interrupts masked, `pad_oe` is 0 and `irq` is 0.
- R2: A write inside offsets 0x000–0x3FC updates the output-data bit of pin i only when address bit i+2 is 1. All other output-data bits keep their value.
- R3: A read inside offsets 0x000–0x3FC returns the pin values ANDed with address bits [9:2]. The pin value is the output-data bit for an output pin and the synchronized input for an input pin.
- R4: In the direction register (0x400), bit value 1 makes the pin an output and 0 makes it an input. On a software-owned pin, `pad_oe` equals the direction bit and `pad_out` equals the output-data bit.
- R5: In the mode register (0x420), bit value 1 makes `pad_out` and `pad_oe` of that pin follow `periph_out` and `periph_oe`. Bit value 0 keeps the pin under software control (R4).
- R6: A pin change driven before clock edge 1 is sampled through two flops. A latched edge appears in raw status (0x414) after edge 3. A level condition appears after edge 2.
- R7: Sense register (0x404) bit value 0 selects edge mode. In edge mode, both-edges register (0x408) bit value 1 latches on either edge. Otherwise event register (0x40C) bit value 1 latches on rising edges and 0 on falling edges. All configuration registers read back what was written.
- R8: Sense bit value 1 selects level mode. Raw status then equals 1 while the synchronized input equals the event bit, and clear writes do not remove it.
- R9: Writing to the clear register (0x41C) drops the latched edge of every pin whose data bit is 1. Bits written as 0 have no effect, and the register reads 0.
- R10: When a new edge on a pin is detected in the same cycle as a clear write to that pin, the edge wins and the raw status bit stays 1.
- R11: Masked status (0x418) equals raw status ANDed with the enable register (0x410).
- R12: `irq` is the OR of the masked status bits, registered. It follows a change in masked status one clock later and is 1 only if some enable bit was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, 0 otherwise |
| pin_in | input | 8 | Pad input values, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| periph_out | input | 8 | Peripheral-side output values |
| periph_oe | input | 8 | Peripheral-side output enables |
| irq | output | 1 | Port interrupt |

## Verification
The bench sweeps all 256 address masks for writes and reads. A design that decoded the mask from the wrong address bits, or that wrote unmasked pins, would corrupt neighbouring outputs or return extra pins. It runs 256 pin patterns through a port where the eight pins cover all eight sense, both-edge and polarity combinations, clearing partial masks as it goes. A swapped polarity, or a level bit that can be cleared, shows up as a raw-status mismatch. The bench also counts sync latency edge by edge, places a clear write exactly on the cycle a new edge latches to catch a clear-wins priority, and steps the enable register through every value to catch an unregistered or unmasked interrupt line.

// File: rtl/gpio_masked_port_pkg.sv
package gpio_masked_port_pkg;

  // Register offsets; the control block sits directly above the masked data window
  localparam logic [11:0] OFS_DIR   = 12'h400;
  localparam logic [11:0] OFS_SENSE = 12'h404;
  localparam logic [11:0] OFS_BOTH  = 12'h408;
  localparam logic [11:0] OFS_EVENT = 12'h40C;
  localparam logic [11:0] OFS_IE    = 12'h410;
  localparam logic [11:0] OFS_RAW   = 12'h414;
  localparam logic [11:0] OFS_MIS   = 12'h418;
  localparam logic [11:0] OFS_CLR   = 12'h41C;
  localparam logic [11:0] OFS_MODE  = 12'h420;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_IE,
    SEL_RAW,
    SEL_MIS,
    SEL_CLR,
    SEL_MODE
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_masked_port_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_val,
  input  logic [NPINS-1:0]  raw_st,
  input  logic [NPINS-1:0]  mis_st,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  event_q,
  output logic [NPINS-1:0]  ie_q,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  data_wmask,
  output logic [NPINS-1:0]  clr_pulse
);

  // The data window spans one word per mask value
  localparam int unsigned      DATA_SPAN = 4 << NPINS;
  localparam logic [ADDR_W-1:0] SPAN_A   = ADDR_W'(DATA_SPAN);

  reg_sel_e           sel;
  logic               wr_en;
  logic               rd_en;
  logic [NPINS-1:0]   addr_mask;
  logic [NPINS-1:0]   wd;
  logic [NPINS-1:0]   rd_pins;
  logic               unused_bits;

  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign addr_mask = bus_addr[NPINS+1:2];
  assign wd        = bus_wdata[NPINS-1:0];
  assign unused_bits = ^{bus_wdata[DATA_W-1:NPINS], bus_addr[1:0]};

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr < SPAN_A) begin
      sel = SEL_DATA;
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_DIR):   sel = SEL_DIR;
        ADDR_W'(OFS_SENSE): sel = SEL_SENSE;
        ADDR_W'(OFS_BOTH):  sel = SEL_BOTH;
        ADDR_W'(OFS_EVENT): sel = SEL_EVENT;
        ADDR_W'(OFS_IE):    sel = SEL_IE;
        ADDR_W'(OFS_RAW):   sel = SEL_RAW;
        ADDR_W'(OFS_MIS):   sel = SEL_MIS;
        ADDR_W'(OFS_CLR):   sel = SEL_CLR;
        ADDR_W'(OFS_MODE):  sel = SEL_MODE;
        default:            sel = SEL_NONE;
      endcase
    end
  end

  // Per-cycle strobes toward the output-data and detector logic
  assign data_wmask = (wr_en && sel == SEL_DATA) ? addr_mask : '0;
  assign clr_pulse  = (wr_en && sel == SEL_CLR)  ? wd        : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ie_q    <= '0;
      mode_q  <= '0;
      dout_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA:  dout_q  <= (dout_q & ~addr_mask) | (wd & addr_mask);
        SEL_DIR:   dir_q   <= wd;
        SEL_SENSE: sense_q <= wd;
        SEL_BOTH:  both_q  <= wd;
        SEL_EVENT: event_q <= wd;
        SEL_IE:    ie_q    <= wd;
        SEL_MODE:  mode_q  <= wd;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA:  rd_pins = pin_val & addr_mask;
      SEL_DIR:   rd_pins = dir_q;
      SEL_SENSE: rd_pins = sense_q;
      SEL_BOTH:  rd_pins = both_q;
      SEL_EVENT: rd_pins = event_q;
      SEL_IE:    rd_pins = ie_q;
      SEL_RAW:   rd_pins = raw_st;
      SEL_MIS:   rd_pins = mis_st;
      SEL_MODE:  rd_pins = mode_q;
      default:   rd_pins = '0;
    endcase
  end

  assign bus_rdata = rd_en ? {{(DATA_W-NPINS){1'b0}}, rd_pins} : '0;

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic sense_lvl,
  input  logic both_edges,
  input  logic event_hi,
  input  logic clr,
  output logic sync_o,
  output logic trig_o,
  output logic latch_o,
  output logic raw_o
);

  logic meta_q;
  logic sync_q;
  logic prev_q;
  logic latch_q;
  logic rise;
  logic fall;
  logic picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise   = sync_q & ~prev_q;
  assign fall   = ~sync_q & prev_q;
  assign picked = both_edges ? (rise | fall) : (event_hi ? rise : fall);
  assign trig_o = ~sense_lvl & picked;

  // Set dominates clear: an edge seen in a clear cycle is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= trig_o | (latch_q & ~clr);
  end

  assign sync_o  = sync_q;
  assign latch_o = latch_q;
  assign raw_o   = sense_lvl ? (sync_q == event_hi) : latch_q;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned NPINS = 8
) (
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] dout_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_out[i] = mode_q[i] ? periph_out[i] : dout_q[i];
    assign pad_oe[i]  = mode_q[i] ? periph_oe[i]  : dir_q[i];
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  periph_out,
  input  logic [NPINS-1:0]  periph_oe,
  output logic              irq
);

  logic [NPINS-1:0] dir_q, sense_q, both_q, event_q, ie_q, mode_q, dout_q;
  logic [NPINS-1:0] data_wmask, clr_pulse;
  logic [NPINS-1:0] sync_v, edge_trig, edge_lat, raw_st, mis_st, pin_val;
  logic             irq_q;

  gpio_port_regs #(
    .NPINS (NPINS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_val   (pin_val),
    .raw_st    (raw_st),
    .mis_st    (mis_st),
    .dir_q     (dir_q),
    .sense_q   (sense_q),
    .both_q    (both_q),
    .event_q   (event_q),
    .ie_q      (ie_q),
    .mode_q    (mode_q),
    .dout_q    (dout_q),
    .data_wmask(data_wmask),
    .clr_pulse (clr_pulse)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    gpio_pin_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_in[i]),
      .sense_lvl (sense_q[i]),
      .both_edges(both_q[i]),
      .event_hi  (event_q[i]),
      .clr       (clr_pulse[i]),
      .sync_o    (sync_v[i]),
      .trig_o    (edge_trig[i]),
      .latch_o   (edge_lat[i]),
      .raw_o     (raw_st[i])
    );
  end

  // Output pins read back their driven value, input pins their sampled level
  assign pin_val = (dir_q & dout_q) | (~dir_q & sync_v);
  assign mis_st  = raw_st & ie_q;

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .mode_q    (mode_q),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .periph_out(periph_out),
    .periph_oe (periph_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |mis_st;
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] mode_q,
  input logic [NPINS-1:0] ie_q,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] data_wmask,
  input logic [NPINS-1:0] clr_pulse,
  input logic [NPINS-1:0] edge_trig,
  input logic [NPINS-1:0] edge_lat
);

  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_q ^ $past(dout_q)) & ~$past(data_wmask)) == '0);

  a_r4_oe_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q & ~mode_q) == '0);

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_pulse) |=> ((edge_lat & $past(clr_pulse & ~edge_trig)) == '0));

  a_r9_no_fall_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (~edge_lat & $past(edge_lat) & ~$past(clr_pulse)) == '0);

  a_r10_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_pulse & edge_trig)) |=>
      ((edge_lat & $past(clr_pulse & edge_trig)) == $past(clr_pulse & edge_trig)));

  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(ie_q) != '0));

endmodule

bind gpio_masked_port gpio_masked_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .dir_q     (dir_q),
  .mode_q    (mode_q),
  .ie_q      (ie_q),
  .dout_q    (dout_q),
  .data_wmask(data_wmask),
  .clr_pulse (clr_pulse),
  .edge_trig (edge_trig),
  .edge_lat  (edge_lat)
);

// File: tb/gpio_masked_port_bench.sv
module gpio_masked_port_bench;
  import gpio_masked_port_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_out, pad_oe;
  logic [7:0]  periph_out = '0;
  logic [7:0]  periph_oe = '0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_masked_port u_gpio_masked_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_oe(periph_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Sweep configuration: pin i has sense=i[2], both=i[1], event=i[0]
  function automatic logic [7:0] edge_model(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] t;
    for (int i = 0; i < 4; i++) begin
      logic r, f;
      r = n[i] & ~o[i];
      f = ~n[i] & o[i];
      t[i] = i[1] ? (r | f) : (i[0] ? r : f);
    end
    for (int i = 4; i < 8; i++) t[i] = 1'b0;
    return t;
  endfunction

  function automatic logic [7:0] raw_model(input logic [7:0] cur, input logic [7:0] lat);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i >= 4) ? (cur[i] == i[0]) : lat[i];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 120000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  dmod, lat, cur, rv;
    logic [11:0] regs [9];
    regs = '{OFS_DIR, OFS_SENSE, OFS_BOTH, OFS_EVENT, OFS_IE, OFS_RAW, OFS_MIS, OFS_CLR, OFS_MODE};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 9; i++) begin
      rd(regs[i], d);
      chk("R1 register after reset", d, 32'h0);
    end
    rd(12'h3FC, d);
    chk("R1 data after reset", d, 32'h0);
    chk("R1 pad_oe after reset", {24'h0, pad_oe}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2/R4: masked writes over every mask, all pins outputs
    wr(OFS_DIR, 32'hFF);
    rd(OFS_DIR, d);
    chk("R7 direction readback", d, 32'hFF);
    dmod = '0;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] wv;
      wv = 8'(m * 73 + 11);
      wr(12'(m << 2), {24'hA5A5A5, wv});
      dmod = (dmod & ~8'(m)) | (wv & 8'(m));
      #1;
      chk("R4 pad_out after masked write (R2)", {24'h0, pad_out}, {24'h0, dmod});
      chk("R4 pad_oe follows direction", {24'h0, pad_oe}, 32'hFF);
      rd(12'h3FC, d);
      chk("R2 full-mask readback", d, {24'h0, dmod});
    end

    // R3: masked reads of input pins over every mask
    wr(OFS_DIR, 32'h00);
    @(negedge clk); pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      rd(12'(m << 2), d);
      chk("R3 masked input read", d, {24'h0, 8'hA5 & 8'(m)});
    end
    // R3: mixed directions, example mask 0xC3
    wr(OFS_DIR, 32'h0F);
    @(negedge clk); pin_in = 8'h81;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m += 17) begin
      rd(12'(m << 2), d);
      chk("R3 mixed-direction read", d, {24'h0, ((dmod & 8'h0F) | (8'h81 & 8'hF0)) & 8'(m)});
    end
    wr(OFS_DIR, 32'h00);
    rd(12'(8'hC3 << 2), d);
    chk("R3 mask C3 example", d, 32'h81);

    // R5: peripheral hand-over for every mode value
    wr(OFS_DIR, 32'h3C);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] po, pe;
      wr(OFS_MODE, 32'(a));
      po = 8'(a * 3 + 1);
      pe = ~8'(a * 5);
      periph_out = po; periph_oe = pe;
      #1;
      chk("R5 pad_out select", {24'h0, pad_out}, {24'h0, (po & 8'(a)) | (dmod & ~8'(a))});
      chk("R5 pad_oe select", {24'h0, pad_oe}, {24'h0, (pe & 8'(a)) | (8'h3C & ~8'(a))});
    end
    wr(OFS_MODE, 32'h0);
    wr(OFS_DIR, 32'h0);

    // R6: synchronizer latency, rising edge on pin 1
    @(negedge clk); pin_in = 8'h00;
    wr(OFS_SENSE, 32'h00);
    wr(OFS_BOTH, 32'h00);
    wr(OFS_EVENT, 32'h02);
    repeat (3) @(negedge clk);
    wr(OFS_CLR, 32'hFF);
    @(negedge clk); pin_in = 8'h02;
    rd(OFS_RAW, d); chk("R6 edge not yet latched (edge 1)", d, 32'h00);
    rd(OFS_RAW, d); chk("R6 edge not yet latched (edge 2)", d, 32'h00);
    rd(OFS_RAW, d); chk("R6 edge latched after edge 3", d, 32'h02);
    // R6/R8: level condition on pin 2 after two edges
    wr(OFS_SENSE, 32'h04);
    wr(OFS_EVENT, 32'h06);
    @(negedge clk); pin_in = 8'h06;
    rd(OFS_RAW, d); chk("R6 level not yet seen", d, 32'h02);
    rd(OFS_RAW, d); chk("R6 level seen after edge 2", d, 32'h06);

    // R10: new edge in the clear cycle wins; R9/R8 controls
    wr(OFS_BOTH, 32'h01);
    wr(OFS_CLR, 32'hFF);
    rd(OFS_RAW, d); chk("R8 level survives clear", d, 32'h04);
    @(negedge clk); pin_in = 8'h07;
    repeat (3) @(negedge clk);
    rd(OFS_RAW, d); chk("R7 both-edge latch", d, 32'h05);
    @(negedge clk); pin_in = 8'h06;
    @(negedge clk);
    wr(OFS_CLR, 32'h01);
    rd(OFS_RAW, d); chk("R10 edge wins over clear", d, 32'h05);
    wr(OFS_CLR, 32'h01);
    rd(OFS_RAW, d); chk("R9 clear drops latched edge", d, 32'h04);
    rd(OFS_CLR, d); chk("R9 clear register reads 0", d, 32'h00);

    // R7/R8/R9: all mode combinations over 256 pin patterns
    wr(OFS_SENSE, 32'hF0);
    wr(OFS_BOTH, 32'hCC);
    wr(OFS_EVENT, 32'hAA);
    rd(OFS_SENSE, d); chk("R7 sense readback", d, 32'hF0);
    rd(OFS_BOTH, d);  chk("R7 both readback", d, 32'hCC);
    rd(OFS_EVENT, d); chk("R7 event readback", d, 32'hAA);
    @(negedge clk); pin_in = 8'h00; cur = 8'h00;
    repeat (4) @(negedge clk);
    wr(OFS_CLR, 32'hFF);
    lat = '0;
    for (int k = 0; k < 256; k++) begin
      logic [7:0] nv;
      nv = 8'(k * 157 + 3);
      @(negedge clk); pin_in = nv;
      repeat (3) @(negedge clk);
      lat = lat | edge_model(cur, nv);
      cur = nv;
      rd(OFS_RAW, d);
      chk("R7 R8 raw status", d, {24'h0, raw_model(cur, lat)});
      if (k % 4 == 0) begin
        wr(OFS_CLR, 32'hFFFFFF00);
        rd(OFS_RAW, d);
        chk("R9 zero clear has no effect", d, {24'h0, raw_model(cur, lat)});
      end
      if (k % 2 == 1) begin
        logic [7:0] cm;
        cm = 8'(k * 29);
        wr(OFS_CLR, {24'h0, cm});
        lat = lat & ~cm;
        rd(OFS_RAW, d);
        chk("R9 partial clear", d, {24'h0, raw_model(cur, lat)});
      end
    end

    // R11/R12: every enable value against a fixed raw status
    @(negedge clk); pin_in = 8'h3C; cur = 8'h3C;
    repeat (4) @(negedge clk);
    lat = lat | edge_model(8'(255 * 157 + 3), 8'h3C);
    rv = raw_model(cur, lat);
    rd(OFS_RAW, d); chk("R11 raw before enable sweep", d, {24'h0, rv});
    for (int e = 0; e < 256; e++) begin
      logic prev_irq;
      prev_irq = irq;
      wr(OFS_IE, 32'(e));
      chk("R12 irq is registered", {31'h0, irq}, {31'h0, prev_irq});
      rd(OFS_MIS, d);
      chk("R11 masked status", d, {24'h0, rv & 8'(e)});
      chk("R12 irq follows masked status", {31'h0, irq}, {31'h0, |(rv & 8'(e))});
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule